// File: doc/BRIEF.md
# Occupancy-Bitmap Minimum Distance Finder

This block receives a full vector of unsigned distances, one per processing element, in a single cycle and reports the smallest distance together with the number of the element that produced it. It does not use a comparator tree. Every distance value is used as an address into a one-bit-per-value occupancy map. Entries that are addressed become occupied. The smallest distance is then the lowest occupied address.

The search for that address runs in two levels, because each lookup group has only a small fan-in. The map is cut into fixed-size groups, and each group is reduced to an "anything here" flag. The lowest flagged group is selected, and then the lowest set bit inside that group is located. A final stage compares every distance against the minimum that was found and priority-encodes the lowest matching element number. The map is rebuilt from nothing for every search. The whole path is a fixed pipeline, so a new search may start on every cycle.

Top module: `min_dist_finder`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `done_o` is 0.
- R2: Distance of element p is carried on `dist_i[p*DIST_W +: DIST_W]` (unsigned). When a search completes, `min_dist_o` equals the smallest of the NUM_PE distances.
- R3: `min_idx_o` is the lowest element number whose distance equals `min_dist_o`, so ties resolve to the smallest index.
- R4: If all distances are equal, `min_dist_o` is that value and `min_idx_o` is 0.
- R5: A distance of 0 is found as the minimum, occupying map entry 0.
- R6: The largest code (all ones, 255 by default) is found correctly when every element holds it.
- R7: `start_i` sampled high at a rising edge makes `done_o` high for exactly one cycle, after the fourth following rising edge. The latency is fixed at 5 edges, counting the capture edge.
- R8: Searches started on consecutive cycles each return their own result. No occupancy mark from an earlier search affects a later one.
- R9: With `start_i` held low, `done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Distance vector valid, starts a search |
| dist_i | input | NUM_PE*DIST_W | Packed distances, element p at bits p*DIST_W upward |
| done_o | output | 1 | One-cycle result valid |
| min_dist_o | output | DIST_W | Smallest distance |
| min_idx_o | output | $clog2(NUM_PE) | Lowest element holding the smallest distance |

## Verification
The hardest case to create from the ports is stale occupancy. The risk is that marks left by one search survive into the next search while both searches are in flight in the pipeline. The stimulus covers this by issuing back-to-back starts. The first vector holds a small minimum. The second vector holds only large values, so any leftover mark would show up as a wrong, too-small result. Ties spread over many elements, including the case where every element is equal, are driven deliberately. This exercises the last-stage index encoder, whose low-index preference cannot be seen from random vectors.

// File: rtl/mdf_pkg.sv
// Package: shared defaults for the minimum distance finder.
// Assumes distances are unsigned and the map covers every code value.
package mdf_pkg;
    localparam int NUM_PE_DEF  = 256;  // distances per search
    localparam int DIST_W_DEF  = 8;    // bits per distance
    localparam int GROUP_W_DEF = 16;   // occupancy entries per lookup group
    localparam int PIPE_LAT    = 5;    // edges from start capture to done
endpackage

// File: rtl/mdf_first_one.sv
// Module: combinational lowest-set-bit encoder.
// Assumes WIDTH >= 2. idx_o is 0 when no bit is set; any_o flags presence.
module mdf_first_one #(
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    // Scan downward so the lowest set bit wins.
    always_comb begin
        idx_o = '0;
        any_o = |vec_i;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = i[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/mdf_occ_map.sv
// Module: marks one occupancy bit per distance value, then registers the map.
// Assumes every distance is below 2**DIST_W; the map starts empty each search.
module mdf_occ_map #(
    parameter int NUM_PE = 256,
    parameter int DIST_W = 8,
    localparam int K = 2 ** DIST_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic [NUM_PE*DIST_W-1:0] dist_i,
    output logic                     valid_o,
    output logic [K-1:0]             map_o
);
    logic [K-1:0] map_next;

    // Build a fresh map: each distance addresses and occupies one entry.
    always_comb begin
        map_next = '0;
        for (int p = 0; p < NUM_PE; p++) begin
            map_next[dist_i[p*DIST_W +: DIST_W]] = 1'b1;
        end
    end

    // Register the map and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            map_o   <= '0;
        end else begin
            valid_o <= valid_i;
            map_o   <= map_next;
        end
    end

    AST_MAP_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (map_o != '0)); // R2
endmodule

// File: rtl/mdf_grp_search.sv
// Module: first-level search; reduces groups to flags and picks the lowest flagged group.
// Assumes K is a multiple of GROUP_W and GROUP_W >= 2.
module mdf_grp_search #(
    parameter int K       = 256,
    parameter int GROUP_W = 16,
    localparam int NUM_GRP = K / GROUP_W,
    localparam int GRP_IW  = $clog2(NUM_GRP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [K-1:0]       map_i,
    output logic               valid_o,
    output logic [GRP_IW-1:0]  grp_o,
    output logic [GROUP_W-1:0] bits_o
);
    logic [NUM_GRP-1:0] flags;
    logic [GRP_IW-1:0]  grp_sel;
    logic               grp_any;

    // One OR-reduce per group gives the any-occupied flag.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_flag
        assign flags[g] = |map_i[g*GROUP_W +: GROUP_W];
    end

    mdf_first_one #(.WIDTH(NUM_GRP)) i_grp_pick (
        .vec_i (flags),
        .idx_o (grp_sel),
        .any_o (grp_any)
    );

    // Register the chosen group number and its contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            grp_o   <= '0;
            bits_o  <= '0;
        end else begin
            valid_o <= valid_i && grp_any;
            grp_o   <= grp_sel;
            bits_o  <= map_i[grp_sel*GROUP_W +: GROUP_W];
        end
    end

    AST_GRP_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (bits_o != '0)); // R2
    AST_GRP_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o); // R7
endmodule

// File: rtl/mdf_bit_search.sv
// Module: second-level search; finds the lowest set bit in the chosen group
// and joins it with the group number to form the minimum distance.
// Assumes the incoming group is non-empty whenever valid_i is high.
module mdf_bit_search #(
    parameter int GROUP_W = 16,
    parameter int GRP_IW  = 4,
    localparam int BIT_IW = $clog2(GROUP_W),
    localparam int DIST_W = GRP_IW + BIT_IW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [GRP_IW-1:0]  grp_i,
    input  logic [GROUP_W-1:0] bits_i,
    output logic               valid_o,
    output logic [DIST_W-1:0]  min_o
);
    logic [BIT_IW-1:0] bit_sel;
    logic              bit_any;

    mdf_first_one #(.WIDTH(GROUP_W)) i_bit_pick (
        .vec_i (bits_i),
        .idx_o (bit_sel),
        .any_o (bit_any)
    );

    // Register the minimum as {group, position in group}.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            min_o   <= '0;
        end else begin
            valid_o <= valid_i && bit_any;
            min_o   <= {grp_i, bit_sel};
        end
    end
endmodule

// File: rtl/mdf_idx_resolve.sv
// Module: finds the lowest element whose distance equals the found minimum.
// Assumes at least one element matches whenever valid_i is high.
module mdf_idx_resolve #(
    parameter int NUM_PE = 256,
    parameter int DIST_W = 8,
    localparam int IDX_W = $clog2(NUM_PE)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic [DIST_W-1:0]        min_i,
    input  logic [NUM_PE*DIST_W-1:0] dist_i,
    output logic                     done_o,
    output logic [DIST_W-1:0]        min_o,
    output logic [IDX_W-1:0]         idx_o
);
    logic [NUM_PE-1:0] match;
    logic [IDX_W-1:0]  idx_sel;
    logic              idx_any;
    logic [NUM_PE*DIST_W-1:0] dist_q;

    // One equality compare per element against the minimum.
    for (genvar p = 0; p < NUM_PE; p++) begin : g_match
        assign match[p] = (dist_i[p*DIST_W +: DIST_W] == min_i);
    end

    mdf_first_one #(.WIDTH(NUM_PE)) i_idx_pick (
        .vec_i (match),
        .idx_o (idx_sel),
        .any_o (idx_any)
    );

    // Register the final result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            min_o  <= '0;
            idx_o  <= '0;
            dist_q <= '0;
        end else begin
            done_o <= valid_i && idx_any;
            min_o  <= min_i;
            idx_o  <= idx_sel;
            dist_q <= dist_i;
        end
    end

    AST_WIN_IS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (dist_q[idx_o*DIST_W +: DIST_W] == min_o)); // R3
    AST_MATCH_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> idx_any); // R2
endmodule

// File: rtl/min_dist_finder.sv
// Module: top of the occupancy-bitmap minimum distance finder.
// Pipeline: capture -> mark map -> pick group -> pick bit -> resolve index.
// Assumes GROUP_W divides 2**DIST_W and both are powers of two.
module min_dist_finder
    import mdf_pkg::*;
#(
    parameter int NUM_PE  = NUM_PE_DEF,
    parameter int DIST_W  = DIST_W_DEF,
    parameter int GROUP_W = GROUP_W_DEF,
    localparam int K      = 2 ** DIST_W,
    localparam int GRP_IW = $clog2(K / GROUP_W),
    localparam int IDX_W  = $clog2(NUM_PE),
    localparam int VEC_W  = NUM_PE * DIST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VEC_W-1:0]  dist_i,
    output logic              done_o,
    output logic [DIST_W-1:0] min_dist_o,
    output logic [IDX_W-1:0]  min_idx_o
);
    logic               s0_valid;
    logic [VEC_W-1:0]   s0_dist, s1_dist, s2_dist, s3_dist;
    logic               s1_valid, s2_valid, s3_valid;
    logic [K-1:0]       s1_map;
    logic [GRP_IW-1:0]  s2_grp;
    logic [GROUP_W-1:0] s2_bits;
    logic [DIST_W-1:0]  s3_min;

    // Capture the input vector and its valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_valid <= 1'b0;
            s0_dist  <= '0;
        end else begin
            s0_valid <= start_i;
            s0_dist  <= dist_i;
        end
    end

    // Carry the distance vector alongside the search stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_dist <= '0;
            s2_dist <= '0;
            s3_dist <= '0;
        end else begin
            s1_dist <= s0_dist;
            s2_dist <= s1_dist;
            s3_dist <= s2_dist;
        end
    end

    mdf_occ_map #(.NUM_PE(NUM_PE), .DIST_W(DIST_W)) i_occ_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (s0_valid),
        .dist_i  (s0_dist),
        .valid_o (s1_valid),
        .map_o   (s1_map)
    );

    mdf_grp_search #(.K(K), .GROUP_W(GROUP_W)) i_grp_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (s1_valid),
        .map_i   (s1_map),
        .valid_o (s2_valid),
        .grp_o   (s2_grp),
        .bits_o  (s2_bits)
    );

    mdf_bit_search #(.GROUP_W(GROUP_W), .GRP_IW(GRP_IW)) i_bit_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (s2_valid),
        .grp_i   (s2_grp),
        .bits_i  (s2_bits),
        .valid_o (s3_valid),
        .min_o   (s3_min)
    );

    mdf_idx_resolve #(.NUM_PE(NUM_PE), .DIST_W(DIST_W)) i_idx_resolve (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (s3_valid),
        .min_i   (s3_min),
        .dist_i  (s3_dist),
        .done_o  (done_o),
        .min_o   (min_dist_o),
        .idx_o   (min_idx_o)
    );

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o == $past(start_i, PIPE_LAT)); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !s3_valid |=> !done_o); // R9
endmodule

// File: tb/test_min_dist_finder.sv
module test_min_dist_finder;
    localparam int NPE = 256;
    localparam int DW  = 8;
    localparam int IW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [NPE*DW-1:0] dist_i = '0;
    logic              done_o;
    logic [DW-1:0]     min_dist_o;
    logic [IW-1:0]     min_idx_o;

    int errors = 0;
    int checks = 0;
    int d [NPE];
    int seed = 12345;

    always #2 clk = ~clk;  // 250 MHz

    min_dist_finder i_min_dist_finder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dist_i(dist_i),
        .done_o(done_o), .min_dist_o(min_dist_o), .min_idx_o(min_idx_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [NPE*DW-1:0] pack_d();
        logic [NPE*DW-1:0] v;
        for (int p = 0; p < NPE; p++) v[p*DW +: DW] = d[p][DW-1:0];
        return v;
    endfunction

    function automatic void model(output int mn, output int mi);
        mn = 1 << DW; mi = 0;
        for (int p = 0; p < NPE; p++) if (d[p] < mn) begin mn = d[p]; mi = p; end
    endfunction

    function automatic int lcg();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h00FF_FFFF;
    endfunction

    // Run one search from d[] and check latency, single pulse and results.
    task automatic run_one(input string req);
        int mn, mi;
        model(mn, mi);
        @(negedge clk); dist_i = pack_d(); start_i = 1'b1;
        @(posedge clk);
        @(negedge clk); start_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b0, "R7 early", done_o, 0);
        @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b1, "R7 done", done_o, 1);
        chk(min_dist_o == mn[DW-1:0], {req, " min"}, min_dist_o, mn);
        chk(min_idx_o == mi[IW-1:0], {req, " idx"}, min_idx_o, mi);
        @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b0, "R7 single pulse", done_o, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b0, "R1 in reset", done_o, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(done_o == 1'b0, "R1 after reset", done_o, 0);
    endtask

    task automatic t_idle();
        bit seen = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (done_o) seen = 1;
        end
        chk(!seen, "R9 idle", seen, 0);
    endtask

    task automatic t_random();
        for (int t = 0; t < 6; t++) begin
            for (int p = 0; p < NPE; p++) d[p] = 20 + (lcg() % 236);
            run_one("R2 random");
        end
        for (int p = 0; p < NPE; p++) d[p] = 255 - (p % 200);
        run_one("R2 descending");
    endtask

    task automatic t_ties();
        for (int p = 0; p < NPE; p++) d[p] = 100 + (p % 7);
        d[200] = 33; d[57] = 33; d[130] = 33;
        run_one("R3 tie");
        for (int p = 0; p < NPE; p++) d[p] = 90;
        d[255] = 17;
        run_one("R3 last element");
    endtask

    task automatic t_all_equal();
        for (int p = 0; p < NPE; p++) d[p] = 77;
        run_one("R4 all equal");
    endtask

    task automatic t_zero();
        for (int p = 0; p < NPE; p++) d[p] = 1 + (p % 250);
        d[143] = 0;
        run_one("R5 zero");
    endtask

    task automatic t_max();
        for (int p = 0; p < NPE; p++) d[p] = 255;
        run_one("R6 max");
    endtask

    // Two starts on consecutive cycles; the second has only large values.
    task automatic t_back_to_back();
        int mn_a, mi_a, mn_b, mi_b;
        logic [NPE*DW-1:0] va, vb;
        for (int p = 0; p < NPE; p++) d[p] = 50 + (p % 100);
        d[9] = 3;
        va = pack_d(); model(mn_a, mi_a);
        for (int p = 0; p < NPE; p++) d[p] = 200 + (p % 50);
        d[222] = 150;
        vb = pack_d(); model(mn_b, mi_b);
        @(negedge clk); dist_i = va; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk); dist_i = vb;
        @(posedge clk);
        @(negedge clk); start_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done_o && min_dist_o == mn_a[DW-1:0] && min_idx_o == mi_a[IW-1:0],
            "R8 first", min_dist_o, mn_a);
        @(posedge clk); @(negedge clk);
        chk(done_o == 1'b1, "R8 second done", done_o, 1);
        chk(min_dist_o == mn_b[DW-1:0], "R8 no stale mark", min_dist_o, mn_b);
        chk(min_idx_o == mi_b[IW-1:0], "R8 second idx", min_idx_o, mi_b);
        @(posedge clk); @(negedge clk);
        chk(done_o == 1'b0, "R8 two pulses only", done_o, 0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_random();
        t_ties();
        t_all_equal();
        t_zero();
        t_max();
        t_back_to_back();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule